// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Unit

This block keeps the pending-event flags and the per-source interrupt enables for one 16-bit timer/counter. There are four event sources: counter overflow, compare match A, compare match B and input capture. The timer core sends single-cycle event strobes. A simple register bus sets the enables, clears flags and reads both registers back. The interrupt controller receives one request line per source and returns a per-source acknowledge when it takes the vector.

A compare match is recorded one timer tick late. A strobe is seen on a cycle where the timer clock enable is high, and the flag rises on the next such cycle. A forced compare never raises a flag. In the mode where the capture register serves as the counter's TOP, the capture flag follows a TOP-reached strobe and ignores capture events. A flag is cleared by writing one to its bit or by its acknowledge. When a hardware set and a clear land in the same cycle, the set wins.

Top module: `tmr_irq_unit`

## Requirements
- R1: After reset both registers read zero and every `irq` line is low.
- R2: Both registers use the same bit layout: bit 0 is overflow, bit 1 is compare A, bit 2 is compare B and bit 5 is capture. Bits 7, 6, 4 and 3 read as zero. Address 0 holds the enables and address 1 holds the flags. Any other address reads zero. `bus_rdata` shows the register at the address presented one cycle earlier.
- R3: A write to address 0 loads bits 5, 2, 1 and 0 into the enables. Data on the other bits is dropped.
- R4: `irq` index 0 is overflow, 1 is compare A, 2 is compare B and 3 is capture. An `irq` line is high one cycle after its flag, its enable and `gie` are all one, and is low otherwise.
- R5: Writing a one to a live bit at address 1 clears that flag. Writing a zero, or writing to a reserved bit, leaves the flags unchanged.
- R6: `vec_ack[i]` clears the flag of source i (same index order as R4).
- R7: A compare match strobe seen on a cycle with `tick` high sets its flag at the next cycle that has `tick` high, and not before.
- R8: A match that arrives together with its force strobe does not set the compare flag.
- R9: With `cap_is_top` low, `cap_evt` sets the capture flag and `top_evt` is ignored. With `cap_is_top` high, the roles swap.
- R10: `ovf_evt` sets the overflow flag at the next clock edge, whatever `tick` is.
- R11: When a set and a clear of the same flag occur in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable |
| ovf_evt | input | 1 | Counter overflow strobe |
| cmpa_match | input | 1 | Compare A equality strobe |
| cmpa_force | input | 1 | Compare A forced strobe |
| cmpb_match | input | 1 | Compare B equality strobe |
| cmpb_force | input | 1 | Compare B forced strobe |
| cap_evt | input | 1 | Capture event strobe |
| top_evt | input | 1 | Counter reached TOP strobe |
| cap_is_top | input | 1 | Mode uses the capture register as TOP |
| gie | input | 1 | Global interrupt enable |
| vec_ack | input | 4 | Per-source vector taken |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 4 | Per-source interrupt request |

## Verification
Compare strobes are driven against a tick that runs at one third of the clock rate. Some land on tick cycles and some off them, which shows whether the flag waits exactly one timer tick. Force strobes are sent both alone and with a match, to show that suppression applies only to the match it accompanies. The capture source is exercised in both modes with both strobes, so the selected strobe can be told apart from the ignored one. Clears are tried by write-one, by write-zero, through reserved bits and by acknowledge, including one cycle where a set and a clear collide. All of this runs under masks and `gie` toggled on and off.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int NSRC = 4;

  typedef enum logic [1:0] {
    SRC_OVF  = 2'd0,
    SRC_CMPA = 2'd1,
    SRC_CMPB = 2'd2,
    SRC_CAP  = 2'd3
  } src_e;

  // Register bit carrying a given source; software decodes these positions.
  function automatic int bit_pos(input int src);
    case (src)
      0: bit_pos = 0;
      1: bit_pos = 1;
      2: bit_pos = 2;
      default: bit_pos = 5;
    endcase
  endfunction
endpackage

// File: rtl/tmr_cmp_delay.sv
module tmr_cmp_delay (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic match_s,
  input  logic force_s,
  output logic set_o
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst)       pend <= 1'b0;
    else if (tick) pend <= match_s & ~force_s;
  end

  assign set_o = tick & pend;

  // R8: a forced strobe never arms the flag
  assert_force_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (tick && force_s) |=> !pend);

  // R7: the pending match only ever arms on a timer tick
  assert_pend_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(tick));
endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R11: a set in the same cycle as a clear leaves the flag set
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);

  // R6 (and R5): a clear with no set drops the flag
  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
  import tmr_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] MASK_ADDR = '0,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              ovf_evt,
  input  logic              cmpa_match,
  input  logic              cmpa_force,
  input  logic              cmpb_match,
  input  logic              cmpb_force,
  input  logic              cap_evt,
  input  logic              top_evt,
  input  logic              cap_is_top,
  input  logic              gie,
  input  logic [NSRC-1:0]   vec_ack,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NSRC-1:0]   irq
);
  logic [NSRC-1:0]   set_v, clr_v, flag_q, mask_q;
  logic [DATA_W-1:0] live_bits, flag_rd, mask_rd;
  logic              wr_mask, wr_flag;
  logic              unused_wbits;

  assign wr_mask = bus_we && (bus_addr == MASK_ADDR);
  assign wr_flag = bus_we && (bus_addr == FLAG_ADDR);

  // Compare sources pass through the one-tick delay
  tmr_cmp_delay u_dly_a (
    .clk(clk), .rst(rst), .tick(tick),
    .match_s(cmpa_match), .force_s(cmpa_force), .set_o(set_v[SRC_CMPA])
  );
  tmr_cmp_delay u_dly_b (
    .clk(clk), .rst(rst), .tick(tick),
    .match_s(cmpb_match), .force_s(cmpb_force), .set_o(set_v[SRC_CMPB])
  );

  assign set_v[SRC_OVF] = ovf_evt;
  assign set_v[SRC_CAP] = cap_is_top ? top_evt : cap_evt;

  always_comb begin
    live_bits = '0;
    flag_rd   = '0;
    mask_rd   = '0;
    for (int s = 0; s < NSRC; s++) begin
      live_bits[bit_pos(s)] = 1'b1;
      flag_rd[bit_pos(s)]   = flag_q[s];
      mask_rd[bit_pos(s)]   = mask_q[s];
    end
  end

  assign unused_wbits = ^(bus_wdata & ~live_bits);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam int P = bit_pos(i);

    assign clr_v[i] = (wr_flag && bus_wdata[P]) || vec_ack[i];

    tmr_flag_cell u_flag (
      .clk(clk), .rst(rst), .set_i(set_v[i]), .clr_i(clr_v[i]), .flag_o(flag_q[i])
    );

    always_ff @(posedge clk) begin
      if (rst)          mask_q[i] <= 1'b0;
      else if (wr_mask) mask_q[i] <= bus_wdata[P];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= '0;
    end else begin
      irq <= flag_q & mask_q & {NSRC{gie}};
      if (bus_addr == MASK_ADDR)      bus_rdata <= mask_rd;
      else if (bus_addr == FLAG_ADDR) bus_rdata <= flag_rd;
      else                            bus_rdata <= '0;
    end
  end

  // R2: reserved bits never read as one
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & ~live_bits) == '0);

  // R4: no request leaves without the global enable one cycle earlier
  assert_irq_needs_gie_R4: assert property (@(posedge clk) disable iff (rst)
    (|irq) |-> $past(gie));

  // R4: each request line needs its own enable one cycle earlier
  assert_irq_needs_mask_R4: assert property (@(posedge clk) disable iff (rst)
    ((irq & ~$past(mask_q)) == '0));
endmodule

// File: tb/tmr_irq_unit_test.sv
module tmr_irq_unit_test;
  logic clk = 0, rst = 1, tick;
  logic ovf_evt = 0, cmpa_match = 0, cmpa_force = 0, cmpb_match = 0, cmpb_force = 0;
  logic cap_evt = 0, top_evt = 0, cap_is_top = 0, gie = 0, bus_we = 0;
  logic [3:0] vec_ack = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [3:0] irq;

  int checks = 0, fails = 0, tcnt = 0;
  bit started = 0, done = 0;
  string ph = "R1";

  bit [7:0] m_mask, m_flag, m_rd;
  bit [3:0] m_irq;
  bit m_pa, m_pb;

  always #4 clk = ~clk;

  tmr_irq_unit uut (
    .clk(clk), .rst(rst), .tick(tick), .ovf_evt(ovf_evt),
    .cmpa_match(cmpa_match), .cmpa_force(cmpa_force),
    .cmpb_match(cmpb_match), .cmpb_force(cmpb_force),
    .cap_evt(cap_evt), .top_evt(top_evt), .cap_is_top(cap_is_top),
    .gie(gie), .vec_ack(vec_ack), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Timer clock enable at one third of the system clock
  always @(negedge clk) tcnt <= (tcnt == 2) ? 0 : tcnt + 1;
  assign tick = (tcnt == 0);

  // Behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    bit [7:0] set, clr, nrd;
    bit [3:0] nirq;
    started = 1;
    if (rst) begin
      m_mask = 0; m_flag = 0; m_rd = 0; m_irq = 0; m_pa = 0; m_pb = 0;
    end else begin
      nirq = {m_flag[5], m_flag[2], m_flag[1], m_flag[0]} &
             {m_mask[5], m_mask[2], m_mask[1], m_mask[0]} & {4{gie}};
      nrd = (bus_addr == 0) ? m_mask : (bus_addr == 1) ? m_flag : 8'h00;
      set = 0;
      if (ovf_evt) set[0] = 1;
      if (cap_is_top ? top_evt : cap_evt) set[5] = 1;
      if (tick && m_pa) set[1] = 1;
      if (tick && m_pb) set[2] = 1;
      clr = (bus_we && bus_addr == 1) ? bus_wdata : 8'h00;
      clr = clr | {2'b00, vec_ack[3], 2'b00, vec_ack[2], vec_ack[1], vec_ack[0]};
      m_flag = ((m_flag & ~clr) | set) & 8'h27;
      if (bus_we && bus_addr == 0) m_mask = bus_wdata & 8'h27;
      if (tick) begin
        m_pa = cmpa_match & ~cmpa_force;
        m_pb = cmpb_match & ~cmpb_force;
      end
      m_irq = nirq; m_rd = nrd;
    end
  end

  // Compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      checks += 2;
      if (bus_rdata !== m_rd) begin
        fails++;
        $display("FAIL %s rdata actual=%h expected=%h t=%0t", ph, bus_rdata, m_rd, $time);
      end
      if (irq !== m_irq) begin
        fails++;
        $display("FAIL %s irq actual=%b expected=%b t=%0t", ph, irq, m_irq, $time);
      end
    end
  end

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic strobes_off();
    ovf_evt = 0; cmpa_match = 0; cmpa_force = 0; cmpb_match = 0; cmpb_force = 0;
    cap_evt = 0; top_evt = 0; vec_ack = 0; bus_we = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    cyc(1);
    bus_we = 0; bus_addr = 1;
  endtask

  initial begin
    cyc(3);
    ph = "R1"; bus_addr = 0; cyc(1); rst = 0; cyc(2); bus_addr = 1; cyc(2);

    ph = "R3"; wr(0, 8'hFF); bus_addr = 0; cyc(2); wr(0, 8'hD8); bus_addr = 0; cyc(2);
    wr(0, 8'h27);

    ph = "R10"; gie = 1; bus_addr = 1; ovf_evt = 1; cyc(1); ovf_evt = 0; cyc(3);

    ph = "R4"; gie = 0; cyc(3); gie = 1; wr(0, 8'h26); cyc(2); wr(0, 8'h27); cyc(2);

    ph = "R5"; wr(1, 8'h00); cyc(2); wr(1, 8'hD8); cyc(2); wr(1, 8'h01); cyc(2);

    ph = "R7";
    for (int k = 0; k < 6; k++) begin
      cmpa_match = 1; cyc(1); cmpa_match = 0; cyc(4 + k);
      wr(1, 8'h02); cyc(1);
    end
    cmpb_match = 1; cyc(3); cmpb_match = 0; cyc(5);

    ph = "R8";
    wr(1, 8'h06);
    cmpa_match = 1; cmpa_force = 1; cmpb_match = 1; cmpb_force = 1; cyc(3);
    cmpa_match = 0; cmpb_match = 0; cyc(6);
    cmpa_force = 0; cmpb_force = 0; cmpb_match = 1; cyc(3); cmpb_match = 0; cyc(5);

    ph = "R9";
    cap_is_top = 0; top_evt = 1; cyc(1); top_evt = 0; cyc(2);
    cap_evt = 1; cyc(1); cap_evt = 0; cyc(2); wr(1, 8'h20); cyc(2);
    cap_is_top = 1; cap_evt = 1; cyc(1); cap_evt = 0; cyc(2);
    top_evt = 1; cyc(1); top_evt = 0; cyc(3);

    ph = "R6";
    vec_ack = 4'b1000; cyc(1); vec_ack = 0; cyc(2);
    vec_ack = 4'b0111; cyc(1); vec_ack = 0; cyc(3);

    ph = "R11";
    ovf_evt = 1; cyc(1); ovf_evt = 0; cyc(1);
    ovf_evt = 1; bus_addr = 1; bus_wdata = 8'h01; bus_we = 1; cyc(1);
    strobes_off(); cyc(2);
    ovf_evt = 1; vec_ack = 4'b0001; cyc(1); strobes_off(); cyc(3);

    ph = "R2";
    for (int a = 0; a < 5; a++) begin bus_addr = a[7:0]; cyc(2); end
    bus_addr = 8'hFF; cyc(2); bus_addr = 1; cyc(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule